// File: doc/BRIEF.md
# Trap and Interrupt Context Controller

This block carries out the control-transfer instructions that save or restore processor context. It uses three shadow registers. Slot 0 holds the instruction pointer, slot 1 holds the stack pointer and slot 2 holds the flag word. The decode stage presents an accepted opcode together with an 8-bit immediate, the current instruction pointer, stack pointer, flag word and privilege mode. The block then answers with new values for the instruction pointer, stack pointer and flags. A write strobe qualifies each of the three values, and a completion pulse ends the operation. A privileged opcode issued from user mode produces a fault pulse instead.

A system call or software interrupt enters through a vector table. The block issues a single one-word read at `vec_base + 4*index`, waits for the read data, commits it, and then signals completion. A return and an interrupt return complete in one cycle from the shadow registers. A call also completes in one cycle, and it only records the instruction pointer. The vector table itself, instruction fetch and ordinary branches live elsewhere.

The sequencer has these states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Idle. An operation is accepted only in this state. |
| `ST_QUICK` | One-cycle completion. |
| `ST_FAULT` | Privilege fault. |
| `ST_VREQ` | The vector read request is driven. |
| `ST_VWAIT` | Waiting for read valid. |
| `ST_COMMIT` | The vector data is committed. |
| `ST_DONE` | The completion pulse is driven. |

The transitions are:

- `ST_IDLE` moves to `ST_QUICK` when it accepts a nop, call, return or interrupt return.
- `ST_IDLE` moves to `ST_FAULT` when it accepts a privileged opcode in user mode.
- `ST_IDLE` moves to `ST_VREQ` when it accepts a system call or software interrupt.
- `ST_IDLE` stays in `ST_IDLE` for any other opcode.
- `ST_QUICK` and `ST_FAULT` return to `ST_IDLE` after one cycle.
- `ST_VREQ` moves to `ST_VWAIT`.
- `ST_VWAIT` moves to `ST_COMMIT` once `vec_rvalid` is seen.
- `ST_COMMIT` moves to `ST_DONE`.
- `ST_DONE` returns to `ST_IDLE`.

Top module: `ctx_xfer_ctrl`

## Requirements
- R1: After reset, every output is 0, the sequencer is idle and the three shadow registers hold 0.
- R2: Opcode encoding on `op_code`:
  - 0 is a nop, 160 is a call, 161 is a return, 162 is a system call, 192 is a software interrupt and 193 is an interrupt return.
  - A nop gives `done` in the cycle after acceptance with no update strobe.
  - Any other opcode value is ignored: no `done`, no `priv_fault` and no `vec_req`.
- R3: A call copies `cur_ip` into shadow slot 0. It gives `done` in the cycle after acceptance with no update strobe.
- R4: A return drives `done` and `upd_ip` in the cycle after acceptance, with `new_ip` equal to shadow slot 0. It issues no vector read.
- R5: A system call saves the IP, SP and flags into shadow slots 0, 1 and 2. In the cycle after acceptance it raises `vec_req` for exactly one cycle, with `vec_addr = vec_base + 24` (slot 6).
- R6: A software interrupt performs the same save and request, with `vec_addr = vec_base + 4*op_imm`.
- R7: After a vector request, the block waits for `vec_rvalid`. `done` then rises two cycles after the cycle in which `vec_rvalid` was high. In that cycle all three update strobes are high, and the outputs are set as follows:
  - `new_ip` equals the read data.
  - `new_sp` equals the saved SP.
  - `new_flags` equals the saved flags with bits 16 and 17 cleared.
- R8: An interrupt return drives `done` and all three update strobes in the cycle after acceptance, with the values taken from shadow slots 0, 1 and 2.
- R9: Privilege is set by `cur_mode`, where 0 is privileged and 1 is user.
  - A software interrupt or interrupt return in user mode raises `priv_fault` for one cycle, with no `done`, no update strobe and no vector read, and leaves the shadow registers unchanged.
  - All other opcodes run in either mode.
- R10: An `op_valid` presented while the sequencer is not idle is ignored. It has no effect on the outputs or on the shadow registers.
- R11: `done` and `priv_fault` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Opcode present this cycle |
| op_code | input | 8 | Decoded opcode |
| op_imm | input | 8 | Immediate; selects the vector slot for a software interrupt |
| cur_mode | input | 1 | Current mode (0 privileged, 1 user) |
| cur_ip | input | 32 | Current instruction pointer |
| cur_sp | input | 32 | Current stack pointer |
| cur_flags | input | 32 | Current flag word |
| vec_base | input | 32 | Vector table base address |
| vec_req | output | 1 | Vector read request (one cycle) |
| vec_addr | output | 32 | Vector read address |
| vec_rvalid | input | 1 | Vector read data valid |
| vec_rdata | input | 32 | Vector read data |
| new_ip | output | 32 | Instruction pointer to load |
| new_sp | output | 32 | Stack pointer to load |
| new_flags | output | 32 | Flag word to load |
| upd_ip | output | 1 | Load `new_ip` |
| upd_sp | output | 1 | Load `new_sp` |
| upd_flags | output | 1 | Load `new_flags` |
| done | output | 1 | Operation complete pulse |
| priv_fault | output | 1 | Privilege fault pulse |

## Verification
The bench enters with flags that have bits 16 and 17 set, and checks that these bits are cleared on entry but come back on an interrupt return. A design that masks the saved copy, or skips the mask, would return the wrong flag word at one of the two points.

It drives a rejected privileged opcode with fresh context values, then performs an interrupt return. A design that saves context before its privilege check would return the rejected values instead of the earlier ones.

It presents a call while a vector read is pending, then performs a return. A design that accepts work outside idle would return the wrong address or pulse `done` early.

Immediate slots 9 and 255 test the address scaling, including its top end. Delayed read-valid cycles show whether a design commits before the data arrives.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OPC_NOP   = 8'd0;
    localparam logic [OP_W-1:0] OPC_CALL  = 8'd160;
    localparam logic [OP_W-1:0] OPC_RET   = 8'd161;
    localparam logic [OP_W-1:0] OPC_SCALL = 8'd162;
    localparam logic [OP_W-1:0] OPC_SWI   = 8'd192;
    localparam logic [OP_W-1:0] OPC_IRET  = 8'd193;

    localparam int SCALL_SLOT = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUICK,
        ST_FAULT,
        ST_VREQ,
        ST_VWAIT,
        ST_COMMIT,
        ST_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        OK_NONE,
        OK_NOP,
        OK_CALL,
        OK_RET,
        OK_SCALL,
        OK_SWI,
        OK_IRET
    } op_kind_t;
endpackage

// File: rtl/ctx_op_decode.sv
module ctx_op_decode
    import ctx_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [OP_W-1:0]  opcode,
    input  logic [IDX_W-1:0] imm,
    input  logic             user_mode,
    output op_kind_t         kind,
    output logic             priv_viol,
    output logic             needs_vec,
    output logic [IDX_W-1:0] vec_idx
);
    logic privileged;

    always_comb begin
        unique case (opcode)
            OPC_NOP:   kind = OK_NOP;
            OPC_CALL:  kind = OK_CALL;
            OPC_RET:   kind = OK_RET;
            OPC_SCALL: kind = OK_SCALL;
            OPC_SWI:   kind = OK_SWI;
            OPC_IRET:  kind = OK_IRET;
            default:   kind = OK_NONE;
        endcase
    end

    always_comb begin
        privileged = (kind == OK_SWI) || (kind == OK_IRET);
        priv_viol  = privileged && user_mode;
        needs_vec  = (kind == OK_SCALL) || (kind == OK_SWI);
        vec_idx    = (kind == OK_SWI) ? imm : IDX_W'(SCALL_SLOT);
    end
endmodule

// File: rtl/ctx_shadow_bank.sv
module ctx_shadow_bank #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_ip,
    input  logic          save_all,
    input  logic [DW-1:0] ip_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] flags_in,
    output logic [DW-1:0] sh_ip,
    output logic [DW-1:0] sh_sp,
    output logic [DW-1:0] sh_flags
);
    localparam int NSLOT = 3;

    logic [DW-1:0] wdata [NSLOT];
    logic [DW-1:0] slot  [NSLOT];
    logic          wen   [NSLOT];

    always_comb begin
        wdata[0] = ip_in;
        wdata[1] = sp_in;
        wdata[2] = flags_in;
        wen[0]   = save_ip || save_all;
        wen[1]   = save_all;
        wen[2]   = save_all;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (wen[g]) begin
                slot[g] <= wdata[g];
            end
        end
    end

    assign sh_ip    = slot[0];
    assign sh_sp    = slot[1];
    assign sh_flags = slot[2];
endmodule

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
    import ctx_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 32,
    parameter int IDX_W       = 8,
    parameter int FLAG_CLR_LO = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  op_kind_t         kind,
    input  logic             priv_viol,
    input  logic             needs_vec,
    input  logic [IDX_W-1:0] vec_idx,
    input  logic [AW-1:0]    vec_base,
    input  logic [DW-1:0]    sh_ip,
    input  logic [DW-1:0]    sh_sp,
    input  logic [DW-1:0]    sh_flags,
    input  logic             vec_rvalid,
    input  logic [DW-1:0]    vec_rdata,
    output logic             save_ip,
    output logic             save_all,
    output seq_state_t       state,
    output logic             vec_req,
    output logic [AW-1:0]    vec_addr,
    output logic [DW-1:0]    new_ip,
    output logic [DW-1:0]    new_sp,
    output logic [DW-1:0]    new_flags,
    output logic             upd_ip,
    output logic             upd_sp,
    output logic             upd_flags,
    output logic             done,
    output logic             priv_fault
);
    localparam logic [DW-1:0] CLR_MASK = DW'(3) << FLAG_CLR_LO;

    seq_state_t    state_q, state_d;
    op_kind_t      kind_q;
    logic          accept;
    logic [AW-1:0] vaddr_q;
    logic [DW-1:0] vdata_q;
    logic [DW-1:0] ip_q, sp_q, flags_q;

    assign accept   = (state_q == ST_IDLE) && op_valid;
    assign save_ip  = accept && (kind == OK_CALL);
    assign save_all = accept && needs_vec && !priv_viol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && kind != OK_NONE) begin
                    if (priv_viol)      state_d = ST_FAULT;
                    else if (needs_vec) state_d = ST_VREQ;
                    else                state_d = ST_QUICK;
                end
            end
            ST_QUICK:  state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            ST_VREQ:   state_d = ST_VWAIT;
            ST_VWAIT:  if (vec_rvalid) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= OK_NONE;
            vaddr_q <= '0;
            vdata_q <= '0;
            ip_q    <= '0;
            sp_q    <= '0;
            flags_q <= '0;
        end else begin
            if (accept) begin
                kind_q  <= kind;
                vaddr_q <= vec_base + (AW'(vec_idx) << 2);
                if (kind == OK_RET) begin
                    ip_q <= sh_ip;
                end else if (kind == OK_IRET && !priv_viol) begin
                    ip_q    <= sh_ip;
                    sp_q    <= sh_sp;
                    flags_q <= sh_flags;
                end
            end
            if (state_q == ST_VWAIT && vec_rvalid) begin
                vdata_q <= vec_rdata;
            end
            if (state_q == ST_COMMIT) begin
                ip_q    <= vdata_q;
                sp_q    <= sh_sp;
                flags_q <= sh_flags & ~CLR_MASK;
            end
        end
    end

    always_comb begin
        done       = (state_q == ST_QUICK) || (state_q == ST_DONE);
        priv_fault = (state_q == ST_FAULT);
        vec_req    = (state_q == ST_VREQ);
        upd_ip     = (state_q == ST_DONE) ||
                     ((state_q == ST_QUICK) && (kind_q == OK_RET || kind_q == OK_IRET));
        upd_sp     = (state_q == ST_DONE) || ((state_q == ST_QUICK) && kind_q == OK_IRET);
        upd_flags  = upd_sp;
    end

    assign state     = state_q;
    assign vec_addr  = vaddr_q;
    assign new_ip    = ip_q;
    assign new_sp    = sp_q;
    assign new_flags = flags_q;
endmodule

// File: rtl/ctx_xfer_ctrl.sv
module ctx_xfer_ctrl
    import ctx_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 32,
    parameter int IDX_W       = 8,
    parameter int FLAG_CLR_LO = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic [IDX_W-1:0] op_imm,
    input  logic             cur_mode,
    input  logic [DW-1:0]    cur_ip,
    input  logic [DW-1:0]    cur_sp,
    input  logic [DW-1:0]    cur_flags,
    input  logic [AW-1:0]    vec_base,
    output logic             vec_req,
    output logic [AW-1:0]    vec_addr,
    input  logic             vec_rvalid,
    input  logic [DW-1:0]    vec_rdata,
    output logic [DW-1:0]    new_ip,
    output logic [DW-1:0]    new_sp,
    output logic [DW-1:0]    new_flags,
    output logic             upd_ip,
    output logic             upd_sp,
    output logic             upd_flags,
    output logic             done,
    output logic             priv_fault
);
    op_kind_t         dec_kind;
    logic             dec_priv_viol;
    logic             dec_needs_vec;
    logic [IDX_W-1:0] dec_idx;
    logic             save_ip, save_all;
    logic [DW-1:0]    sh_ip, sh_sp, sh_flags;
    seq_state_t       seq_state;

    ctx_op_decode #(.IDX_W(IDX_W)) u_dec (
        .opcode    (op_code),
        .imm       (op_imm),
        .user_mode (cur_mode),
        .kind      (dec_kind),
        .priv_viol (dec_priv_viol),
        .needs_vec (dec_needs_vec),
        .vec_idx   (dec_idx)
    );

    ctx_shadow_bank #(.DW(DW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .save_ip  (save_ip),
        .save_all (save_all),
        .ip_in    (cur_ip),
        .sp_in    (cur_sp),
        .flags_in (cur_flags),
        .sh_ip    (sh_ip),
        .sh_sp    (sh_sp),
        .sh_flags (sh_flags)
    );

    ctx_seq_fsm #(
        .DW(DW), .AW(AW), .IDX_W(IDX_W), .FLAG_CLR_LO(FLAG_CLR_LO)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .kind       (dec_kind),
        .priv_viol  (dec_priv_viol),
        .needs_vec  (dec_needs_vec),
        .vec_idx    (dec_idx),
        .vec_base   (vec_base),
        .sh_ip      (sh_ip),
        .sh_sp      (sh_sp),
        .sh_flags   (sh_flags),
        .vec_rvalid (vec_rvalid),
        .vec_rdata  (vec_rdata),
        .save_ip    (save_ip),
        .save_all   (save_all),
        .state      (seq_state),
        .vec_req    (vec_req),
        .vec_addr   (vec_addr),
        .new_ip     (new_ip),
        .new_sp     (new_sp),
        .new_flags  (new_flags),
        .upd_ip     (upd_ip),
        .upd_sp     (upd_sp),
        .upd_flags  (upd_flags),
        .done       (done),
        .priv_fault (priv_fault)
    );
endmodule

// File: rtl/ctx_xfer_chk.sv
module ctx_xfer_chk
    import ctx_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 32,
    parameter int IDX_W       = 8,
    parameter int FLAG_CLR_LO = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [OP_W-1:0]  op_code,
    input logic             cur_mode,
    input logic [AW-1:0]    vec_base,
    input logic             vec_req,
    input logic [AW-1:0]    vec_addr,
    input logic             vec_rvalid,
    input logic [DW-1:0]    new_flags,
    input logic             upd_ip,
    input logic             upd_sp,
    input logic             upd_flags,
    input logic             done,
    input logic             priv_fault,
    input seq_state_t       seq_state
);
    logic idle_take;
    assign idle_take = (seq_state == ST_IDLE) && op_valid;

    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && priv_fault));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> !(upd_ip || upd_sp || upd_flags || done));

    assert_swi_user_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_take && op_code == OPC_SWI && cur_mode) |=> priv_fault);

    assert_ret_quick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_take && op_code == OPC_RET) |=> (done && upd_ip && !vec_req));

    assert_scall_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_take && op_code == OPC_SCALL) |=>
            (vec_req && vec_addr == $past(vec_base) + AW'(24)));

    assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> !vec_req);

    assert_entry_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_DONE) |-> (new_flags[FLAG_CLR_LO +: 2] == 2'b00));

    assert_wait_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_VWAIT && !vec_rvalid) |=> (!done && !priv_fault));
endmodule

bind ctx_xfer_ctrl ctx_xfer_chk #(
    .DW(DW), .AW(AW), .IDX_W(IDX_W), .FLAG_CLR_LO(FLAG_CLR_LO)
) u_ctx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .cur_mode   (cur_mode),
    .vec_base   (vec_base),
    .vec_req    (vec_req),
    .vec_addr   (vec_addr),
    .vec_rvalid (vec_rvalid),
    .new_flags  (new_flags),
    .upd_ip     (upd_ip),
    .upd_sp     (upd_sp),
    .upd_flags  (upd_flags),
    .done       (done),
    .priv_fault (priv_fault),
    .seq_state  (seq_state)
);

// File: tb/tb_ctx_xfer_ctrl.sv
module tb_ctx_xfer_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [7:0]  op_code;
    logic [7:0]  op_imm;
    logic        cur_mode;
    logic [31:0] cur_ip, cur_sp, cur_flags, vec_base;
    logic        vec_req;
    logic [31:0] vec_addr;
    logic        vec_rvalid;
    logic [31:0] vec_rdata;
    logic [31:0] new_ip, new_sp, new_flags;
    logic        upd_ip, upd_sp, upd_flags, done, priv_fault;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    localparam logic [31:0] BASE = 32'h0000_8000;

    always #2 clk = ~clk;

    ctx_xfer_ctrl dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_imm(op_imm), .cur_mode(cur_mode), .cur_ip(cur_ip), .cur_sp(cur_sp),
        .cur_flags(cur_flags), .vec_base(vec_base), .vec_req(vec_req),
        .vec_addr(vec_addr), .vec_rvalid(vec_rvalid), .vec_rdata(vec_rdata),
        .new_ip(new_ip), .new_sp(new_sp), .new_flags(new_flags),
        .upd_ip(upd_ip), .upd_sp(upd_sp), .upd_flags(upd_flags),
        .done(done), .priv_fault(priv_fault)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // {done, priv_fault, vec_req, upd_ip, upd_sp, upd_flags}
    function automatic logic [5:0] ctl();
        return {done, priv_fault, vec_req, upd_ip, upd_sp, upd_flags};
    endfunction

    task automatic issue(input logic [7:0] op, input logic [7:0] imm, input logic mode,
                         input logic [31:0] ip, input logic [31:0] sp, input logic [31:0] fl);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_imm = imm; cur_mode = mode;
        cur_ip = ip; cur_sp = sp; cur_flags = fl;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // called in the cycle after acceptance of an entry opcode
    task automatic vec_flow(input string tag, input logic [31:0] exp_addr, input logic [31:0] rd,
                            input logic [31:0] exp_sp, input logic [31:0] exp_fl, input int gap);
        chk({tag, " req"}, 64'(ctl()), 64'b001000);
        chk({tag, " addr"}, 64'(vec_addr), 64'(exp_addr));
        @(negedge clk);
        chk({tag, " req drop"}, 64'(vec_req), 64'd0);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            chk({tag, " wait quiet R7"}, 64'(ctl()), 64'd0);
        end
        vec_rvalid = 1'b1; vec_rdata = rd;
        @(negedge clk);
        vec_rvalid = 1'b0; vec_rdata = 32'hDEAD_BEEF;
        chk({tag, " commit cycle R7"}, 64'(ctl()), 64'd0);
        @(negedge clk);
        chk({tag, " done strobes R7"}, 64'(ctl()), 64'b100111);
        chk({tag, " ip R7"}, 64'(new_ip), 64'(rd));
        chk({tag, " sp R7"}, 64'(new_sp), 64'(exp_sp));
        chk({tag, " flags R7"}, 64'(new_flags), 64'(exp_fl));
        @(negedge clk);
        chk({tag, " done pulse R11"}, 64'(ctl()), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 control outputs", 64'(ctl()), 64'd0);
        chk("R1 new values", {new_ip, new_sp}, 64'd0);
        chk("R1 addr/flags", {vec_addr, new_flags}, 64'd0);
        // shadows zero: interrupt return yields zeros
        issue(8'd193, 8'd0, 1'b0, 32'h1, 32'h2, 32'h3);
        chk("R1 shadow reset ip/sp", {new_ip, new_sp}, 64'd0);
        chk("R1 shadow reset flags", 64'(new_flags), 64'd0);
    endtask

    task automatic t_nop_unknown();
        issue(8'd0, 8'd0, 1'b1, 32'h5, 32'h6, 32'h7);
        chk("R2 nop done", 64'(ctl()), 64'b100000);
        @(negedge clk);
        chk("R2 nop one pulse R11", 64'(ctl()), 64'd0);
        issue(8'd5, 8'd0, 1'b0, 32'h5, 32'h6, 32'h7);
        chk("R2 unknown ignored", 64'(ctl()), 64'd0);
        issue(8'd163, 8'd0, 1'b0, 32'h5, 32'h6, 32'h7);
        chk("R2 unknown 163 ignored", 64'(ctl()), 64'd0);
    endtask

    task automatic t_call_ret();
        issue(8'd160, 8'd0, 1'b1, 32'h0000_4444, 32'h1, 32'h2);
        chk("R3 call done no strobes", 64'(ctl()), 64'b100000);
        @(negedge clk);
        issue(8'd161, 8'd0, 1'b1, 32'h9999, 32'h1, 32'h2);
        chk("R4 ret strobes", 64'(ctl()), 64'b100100);
        chk("R3 R4 ret ip", 64'(new_ip), 64'h4444);
        @(negedge clk);
        chk("R4 no vector read", 64'(ctl()), 64'd0);
    endtask

    task automatic t_scall();
        issue(8'd162, 8'd0, 1'b1, 32'h0000_1000, 32'h0000_2000, 32'h0003_0005);
        vec_flow("R5 scall", BASE + 32'd24, 32'hAAAA_0000, 32'h2000, 32'h0000_0005, 2);
    endtask

    task automatic t_iret(input string tag, input logic [31:0] ip, input logic [31:0] sp,
                          input logic [31:0] fl);
        issue(8'd193, 8'd0, 1'b0, 32'h7777, 32'h8888, 32'h9999);
        chk({tag, " iret strobes R8"}, 64'(ctl()), 64'b100111);
        chk({tag, " iret ip/sp R8"}, {new_ip, new_sp}, {ip, sp});
        chk({tag, " iret flags R8"}, 64'(new_flags), 64'(fl));
        @(negedge clk);
    endtask

    task automatic t_swi();
        issue(8'd192, 8'd9, 1'b0, 32'h111, 32'h222, 32'hFFFF_FFFF);
        vec_flow("R6 swi slot9", BASE + 32'd36, 32'h5555_0000, 32'h222, 32'hFFFC_FFFF, 0);
        issue(8'd192, 8'd255, 1'b0, 32'h333, 32'h444, 32'h0002_0000);
        vec_flow("R6 swi slot255", BASE + 32'd1020, 32'h6666_0000, 32'h444, 32'h0, 1);
        t_iret("R6 saved", 32'h333, 32'h444, 32'h0002_0000);
    endtask

    task automatic t_priv();
        issue(8'd192, 8'd3, 1'b1, 32'hBAD1, 32'hBAD2, 32'hBAD3);
        chk("R9 swi user fault", 64'(ctl()), 64'b010000);
        @(negedge clk);
        chk("R9 fault single R11", 64'(ctl()), 64'd0);
        issue(8'd193, 8'd0, 1'b1, 32'hBAD4, 32'hBAD5, 32'hBAD6);
        chk("R9 iret user fault", 64'(ctl()), 64'b010000);
        @(negedge clk);
        t_iret("R9 shadows kept", 32'h333, 32'h444, 32'h0002_0000);
    endtask

    task automatic t_busy();
        issue(8'd162, 8'd0, 1'b0, 32'hC0DE, 32'hC1DE, 32'hC2DE);
        chk("R10 req", 64'(vec_req), 64'd1);
        @(negedge clk);
        op_valid = 1'b1; op_code = 8'd160; cur_ip = 32'hF00D;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10 call while busy ignored", 64'(ctl()), 64'd0);
        op_valid = 1'b1; op_code = 8'd161;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10 ret while busy ignored", 64'(ctl()), 64'd0);
        vec_rvalid = 1'b1; vec_rdata = 32'h1234_5678;
        @(negedge clk);
        vec_rvalid = 1'b0;
        @(negedge clk);
        chk("R10 entry completes", 64'(ctl()), 64'b100111);
        chk("R10 entry ip", 64'(new_ip), 64'h1234_5678);
        @(negedge clk);
        issue(8'd161, 8'd0, 1'b0, 32'h0, 32'h0, 32'h0);
        chk("R10 shadow0 not overwritten", 64'(new_ip), 64'hC0DE);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_imm = '0; cur_mode = 1'b0;
        cur_ip = '0; cur_sp = '0; cur_flags = '0; vec_base = BASE;
        vec_rvalid = 1'b0; vec_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nop_unknown();
        t_call_ret();
        t_scall();
        t_iret("R5 R8 after scall", 32'h1000, 32'h2000, 32'h0003_0005);
        t_swi();
        t_priv();
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule